// File: doc/BRIEF.md
# CIP Header Receive Checker

This block examines the header of every isochronous packet that arrives on a serial-bus receive path and decides whether the packet should be kept or discarded. Each header is presented in one cycle: the isochronous packet header and the two quadlets of the common isochronous packet header, qualified by a valid strobe. Only packets whose channel number equals the programmed receive channel are examined. For these the block checks three things. The format code must be one the enables permit. The data block counter must follow on from the previous packet. The encryption-mode (EMI) and odd/even bits are compared with the previous packet.

The results are reported in two ways. Single-cycle interrupt pulses flag each event. Sticky flags record it until software reads status. The most recent source identifier, stream type, EMI, odd/even and field-rate bits are captured for software to read. Programming the channel starts reception and arms a first-packet notification. A stop request ends reception. Payload handling is done elsewhere.

Top module: `cip_rx_checker`

## Requirements
- R1: A header is ignored unless reception is active and the channel field (isochronous header bits 13:8) equals the programmed channel. An ignored header raises no `pkt_valid`, no interrupt and no flag.
- R2: The format code is CIP quadlet 1 bits 29:24. The code 6'h00 is accepted only with `en_dv`, 6'h20 only with `en_ts` and 6'h21 only with `en_dss`. Any other code, or a code whose enable is clear, gives `pkt_keep`=0, `irq_fmt` and `flag_fmt`.
- R3: The DBC is CIP quadlet 0 bits 7:0 and DBS is bits 23:16. The expected DBC is the previous accepted DBC plus that packet's block count, modulo 256. The block count is ((data_length−8)/4)/DBS, where data_length is isochronous header bits 31:16 and DBS=0 means 256. A header-only packet counts zero blocks. A DBC that differs from the expected value gives `pkt_keep`=0, `irq_dbc` and `flag_dbc`, and the tracking resynchronises to the new DBC.
- R4: The first format-accepted packet after reset or after the channel is programmed is checked for neither DBC continuity nor mode change.
- R5: EMI is isochronous header bits 3:2 and odd/even is bit 1. A change in either from the previous accepted packet gives `irq_chg` and `flag_chg`, and the packet is still kept.
- R6: A `stat_rd` pulse clears all sticky flags on the next edge. An event that occurs in the same cycle as the read leaves its flag set.
- R7: `irq_first` pulses once, for the first matching packet after `chan_wr`.
- R8: After reset, reception is inactive. `stop_req` ends reception on the next edge and makes `stop_busy` high for exactly one cycle.
- R9: A format-accepted packet loads the captured fields. These are SID (CIP quadlet 0 bits 29:24), STYPE (quadlet 1 bits 20:16), 50/60 (quadlet 1 bit 23), EMI and odd/even.
- R10: All results appear one clock after the header strobe, and `pkt_valid` is a single-cycle pulse for each matching header.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| hdr_valid | input | 1 | Header quadlets valid this cycle |
| iso_hdr | input | 32 | Isochronous packet header quadlet |
| cip_q0 | input | 32 | First CIP header quadlet |
| cip_q1 | input | 32 | Second CIP header quadlet |
| chan_wr | input | 1 | Program receive channel and start reception |
| chan_in | input | CHAN_W | Receive channel number |
| stop_req | input | 1 | Request to stop reception |
| en_dv | input | 1 | Permit DV format code |
| en_ts | input | 1 | Permit MPEG2-TS format code |
| en_dss | input | 1 | Permit DSS format code |
| stat_rd | input | 1 | Status read strobe, clears sticky flags |
| pkt_valid | output | 1 | Verdict for a matching header is valid |
| pkt_keep | output | 1 | Keep (1) or delete (0) the packet |
| irq_first | output | 1 | First packet after channel programming |
| irq_fmt | output | 1 | Format error pulse |
| irq_dbc | output | 1 | DBC discontinuity pulse |
| irq_chg | output | 1 | EMI or odd/even change pulse |
| flag_fmt | output | 1 | Sticky format error |
| flag_dbc | output | 1 | Sticky DBC discontinuity |
| flag_chg | output | 1 | Sticky mode change |
| rx_active | output | 1 | Reception running |
| stop_busy | output | 1 | Stop in progress |
| cap_sid | output | 6 | Captured source identifier |
| cap_stype | output | 5 | Captured stream type |
| cap_emi | output | 2 | Captured EMI |
| cap_oe | output | 1 | Captured odd/even |
| cap_fs | output | 1 | Captured 50/60 bit |

## Verification
The continuity check is exercised with several packet streams. One stream has in-step counters across multi-block, single-block and header-only packets. Another has a deliberate jump. A third wraps past 255 and a fourth uses DBS=0; between them they separate correct block counting from an off-by-one in the expected value. Format codes are tried with their enable both clear and set, and an unlisted code is also sent, so that a wrong permit mapping shows. Mismatched channels, a channel change, a stop, and a status read that lands in the same cycle as a new error show the filtering, the first-packet skip and the set-wins rule on the flags.

// File: rtl/cip_rx_pkg.sv
package cip_rx_pkg;
   localparam int FLD_CHAN_W = 6;
   localparam int FLD_DBC_W  = 8;
   localparam int FLD_LEN_W  = 16;

   localparam logic [5:0] FMT_CODE_DV  = 6'h00;
   localparam logic [5:0] FMT_CODE_TS  = 6'h20;
   localparam logic [5:0] FMT_CODE_DSS = 6'h21;

   typedef struct packed {
      logic [FLD_LEN_W-1:0]  len;
      logic [FLD_CHAN_W-1:0] chan;
      logic [1:0]            emi;
      logic                  oe;
      logic [5:0]            sid;
      logic [7:0]            dbs;
      logic [FLD_DBC_W-1:0]  dbc;
      logic [5:0]            fmt;
      logic [4:0]            stype;
      logic                  fs;
   } cip_fields_t;

   // index of each event in the flag vector
   localparam int EV_FMT = 0;
   localparam int EV_DBC = 1;
   localparam int EV_CHG = 2;
   localparam int EV_NUM = 3;
endpackage

// File: rtl/cip_hdr_decode.sv
module cip_hdr_decode
   import cip_rx_pkg::*;
#(
   parameter int  DBC_W         = 8,
   parameter bit  DBS0_IS_256   = 1'b1
) (
   input  logic [31:0]       iso_hdr,
   input  logic [31:0]       cip_q0,
   input  logic [31:0]       cip_q1,
   input  logic              en_dv,
   input  logic              en_ts,
   input  logic              en_dss,
   output cip_fields_t       fld,
   output logic              fmt_ok,
   output logic [DBC_W-1:0]  blocks
);
   localparam int QUAD_W = FLD_LEN_W - 2;

   logic [FLD_LEN_W-1:0] len_net;
   logic [QUAD_W-1:0]    quads;
   logic [8:0]           dbs_eff;
   logic [QUAD_W-1:0]    blk_full;
   logic                 unused_bits;

   always_comb begin
      fld.len   = iso_hdr[31:16];
      fld.chan  = iso_hdr[13:8];
      fld.emi   = iso_hdr[3:2];
      fld.oe    = iso_hdr[1];
      fld.sid   = cip_q0[29:24];
      fld.dbs   = cip_q0[23:16];
      fld.dbc   = cip_q0[7:0];
      fld.fmt   = cip_q1[29:24];
      fld.fs    = cip_q1[23];
      fld.stype = cip_q1[20:16];
   end

   assign unused_bits = ^{iso_hdr[15:14], iso_hdr[7:4], iso_hdr[0],
                          cip_q0[31:30], cip_q0[15:8],
                          cip_q1[31:30], cip_q1[22:21], cip_q1[15:0]};

   assign fmt_ok = ((fld.fmt == FMT_CODE_DV)  && en_dv)  ||
                   ((fld.fmt == FMT_CODE_TS)  && en_ts)  ||
                   ((fld.fmt == FMT_CODE_DSS) && en_dss);

   assign len_net = (fld.len >= 16'd8) ? (fld.len - 16'd8) : '0;
   assign quads   = len_net[FLD_LEN_W-1:2];

   generate
      if (DBS0_IS_256) begin : g_dbs_wide
         assign dbs_eff  = (fld.dbs == 8'd0) ? 9'd256 : {1'b0, fld.dbs};
         assign blk_full = quads / {{(QUAD_W-9){1'b0}}, dbs_eff};
      end else begin : g_dbs_zero_empty
         assign dbs_eff  = {1'b0, fld.dbs};
         assign blk_full = (fld.dbs == 8'd0) ? '0 :
                           quads / {{(QUAD_W-9){1'b0}}, dbs_eff};
      end
   endgenerate

   assign blocks = blk_full[DBC_W-1:0];
endmodule

// File: rtl/cip_dbc_track.sv
module cip_dbc_track #(
   parameter int DBC_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             clr,
   input  logic             upd,
   input  logic [DBC_W-1:0] dbc_in,
   input  logic [DBC_W-1:0] blk_in,
   input  logic [1:0]       emi_in,
   input  logic             oe_in,
   output logic             gap,
   output logic             mode_chg
);
   logic             have_prev;
   logic [DBC_W-1:0] prev_dbc;
   logic [DBC_W-1:0] prev_blk;
   logic [1:0]       prev_emi;
   logic             prev_oe;
   logic [DBC_W-1:0] dbc_expect;

   assign dbc_expect = prev_dbc + prev_blk;
   assign gap        = have_prev && (dbc_in != dbc_expect);
   assign mode_chg   = have_prev && ((emi_in != prev_emi) || (oe_in != prev_oe));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         have_prev <= 1'b0;
         prev_dbc  <= '0;
         prev_blk  <= '0;
         prev_emi  <= '0;
         prev_oe   <= 1'b0;
      end else if (clr) begin
         have_prev <= 1'b0;
      end else if (upd) begin
         have_prev <= 1'b1;
         prev_dbc  <= dbc_in;
         prev_blk  <= blk_in;
         prev_emi  <= emi_in;
         prev_oe   <= oe_in;
      end
   end

   // R4
   first_skip_chk: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (!gap && !mode_chg));
endmodule

// File: rtl/cip_sticky_flags.sv
module cip_sticky_flags #(
   parameter int N = 3
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set,
   input  logic         rd,
   output logic [N-1:0] flg
);
   generate
      for (genvar i = 0; i < N; i++) begin : g_flag
         always_ff @(posedge clk) begin
            if (!rst_n) flg[i] <= 1'b0;
            else        flg[i] <= set[i] | (flg[i] & ~rd);
         end

         // R6
         rd_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (rd && !set[i]) |=> !flg[i]);
         // R6
         set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
            set[i] |=> flg[i]);
      end
   endgenerate
endmodule

// File: rtl/cip_rx_checker.sv
module cip_rx_checker
   import cip_rx_pkg::*;
#(
   parameter int CHAN_W      = 6,
   parameter int DBC_W       = 8,
   parameter bit DBS0_IS_256 = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              hdr_valid,
   input  logic [31:0]       iso_hdr,
   input  logic [31:0]       cip_q0,
   input  logic [31:0]       cip_q1,
   input  logic              chan_wr,
   input  logic [CHAN_W-1:0] chan_in,
   input  logic              stop_req,
   input  logic              en_dv,
   input  logic              en_ts,
   input  logic              en_dss,
   input  logic              stat_rd,
   output logic              pkt_valid,
   output logic              pkt_keep,
   output logic              irq_first,
   output logic              irq_fmt,
   output logic              irq_dbc,
   output logic              irq_chg,
   output logic              flag_fmt,
   output logic              flag_dbc,
   output logic              flag_chg,
   output logic              rx_active,
   output logic              stop_busy,
   output logic [5:0]        cap_sid,
   output logic [4:0]        cap_stype,
   output logic [1:0]        cap_emi,
   output logic              cap_oe,
   output logic              cap_fs
);
   generate
      if (CHAN_W != FLD_CHAN_W) begin : g_bad_chan_w
         $error("CHAN_W must equal the 6-bit channel field");
      end
      if (DBC_W != FLD_DBC_W) begin : g_bad_dbc_w
         $error("DBC_W must equal the 8-bit DBC field");
      end
   endgenerate

   cip_fields_t        fld;
   logic               fmt_ok;
   logic [DBC_W-1:0]   blocks;
   logic               gap;
   logic               mode_chg;
   logic [CHAN_W-1:0]  chan_q;
   logic               armed;
   logic               match;
   logic               accept;
   logic [EV_NUM-1:0]  ev_set;
   logic [EV_NUM-1:0]  ev_flag;
   logic               unused_fld;

   assign unused_fld = ^{fld.len, fld.dbs};

   cip_hdr_decode #(.DBC_W(DBC_W), .DBS0_IS_256(DBS0_IS_256)) u_decode (
      .iso_hdr (iso_hdr),
      .cip_q0  (cip_q0),
      .cip_q1  (cip_q1),
      .en_dv   (en_dv),
      .en_ts   (en_ts),
      .en_dss  (en_dss),
      .fld     (fld),
      .fmt_ok  (fmt_ok),
      .blocks  (blocks)
   );

   assign match  = hdr_valid && rx_active && (fld.chan == chan_q);
   assign accept = match && fmt_ok;

   cip_dbc_track #(.DBC_W(DBC_W)) u_track (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (chan_wr),
      .upd      (accept),
      .dbc_in   (fld.dbc),
      .blk_in   (blocks),
      .emi_in   (fld.emi),
      .oe_in    (fld.oe),
      .gap      (gap),
      .mode_chg (mode_chg)
   );

   always_comb begin
      ev_set         = '0;
      ev_set[EV_FMT] = match && !fmt_ok;
      ev_set[EV_DBC] = accept && gap;
      ev_set[EV_CHG] = accept && mode_chg;
   end

   cip_sticky_flags #(.N(EV_NUM)) u_flags (
      .clk   (clk),
      .rst_n (rst_n),
      .set   (ev_set),
      .rd    (stat_rd),
      .flg   (ev_flag)
   );

   assign flag_fmt = ev_flag[EV_FMT];
   assign flag_dbc = ev_flag[EV_DBC];
   assign flag_chg = ev_flag[EV_CHG];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         chan_q    <= '0;
         rx_active <= 1'b0;
         stop_busy <= 1'b0;
         armed     <= 1'b0;
         pkt_valid <= 1'b0;
         pkt_keep  <= 1'b0;
         irq_first <= 1'b0;
         irq_fmt   <= 1'b0;
         irq_dbc   <= 1'b0;
         irq_chg   <= 1'b0;
         cap_sid   <= '0;
         cap_stype <= '0;
         cap_emi   <= '0;
         cap_oe    <= 1'b0;
         cap_fs    <= 1'b0;
      end else begin
         pkt_valid <= match;
         pkt_keep  <= accept && !gap;
         irq_first <= match && armed;
         irq_fmt   <= ev_set[EV_FMT];
         irq_dbc   <= ev_set[EV_DBC];
         irq_chg   <= ev_set[EV_CHG];
         stop_busy <= stop_req;
         if (chan_wr) begin
            chan_q    <= chan_in;
            rx_active <= 1'b1;
            armed     <= 1'b1;
         end else begin
            if (stop_req) rx_active <= 1'b0;
            if (match)    armed     <= 1'b0;
         end
         if (accept) begin
            cap_sid   <= fld.sid;
            cap_stype <= fld.stype;
            cap_emi   <= fld.emi;
            cap_oe    <= fld.oe;
            cap_fs    <= fld.fs;
         end
      end
   end

   // R1
   idle_no_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !rx_active |=> !pkt_valid);
   // R2
   fmt_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_fmt |-> (pkt_valid && !pkt_keep && flag_fmt));
   // R3
   dbc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_dbc |-> (pkt_valid && !pkt_keep && flag_dbc));
   // R5
   chg_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_chg |-> (pkt_valid && flag_chg));
   // R7
   first_with_pkt_chk: assert property (@(posedge clk) disable iff (!rst_n)
      irq_first |-> pkt_valid);
   // R8
   stop_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (stop_req && !chan_wr) |=> (stop_busy && !rx_active));
endmodule

// File: tb/cip_rx_checker_tb.sv
module cip_rx_checker_tb;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        hdr_valid = 1'b0;
   logic [31:0] iso_hdr = '0;
   logic [31:0] cip_q0 = '0;
   logic [31:0] cip_q1 = '0;
   logic        chan_wr = 1'b0;
   logic [5:0]  chan_in = '0;
   logic        stop_req = 1'b0;
   logic        en_dv = 1'b1;
   logic        en_ts = 1'b0;
   logic        en_dss = 1'b1;
   logic        stat_rd = 1'b0;
   logic        pkt_valid, pkt_keep, irq_first, irq_fmt, irq_dbc, irq_chg;
   logic        flag_fmt, flag_dbc, flag_chg, rx_active, stop_busy;
   logic [5:0]  cap_sid;
   logic [4:0]  cap_stype;
   logic [1:0]  cap_emi;
   logic        cap_oe, cap_fs;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #2.5 clk = ~clk;

   cip_rx_checker u_dut (
      .clk(clk), .rst_n(rst_n), .hdr_valid(hdr_valid), .iso_hdr(iso_hdr),
      .cip_q0(cip_q0), .cip_q1(cip_q1), .chan_wr(chan_wr), .chan_in(chan_in),
      .stop_req(stop_req), .en_dv(en_dv), .en_ts(en_ts), .en_dss(en_dss),
      .stat_rd(stat_rd), .pkt_valid(pkt_valid), .pkt_keep(pkt_keep),
      .irq_first(irq_first), .irq_fmt(irq_fmt), .irq_dbc(irq_dbc),
      .irq_chg(irq_chg), .flag_fmt(flag_fmt), .flag_dbc(flag_dbc),
      .flag_chg(flag_chg), .rx_active(rx_active), .stop_busy(stop_busy),
      .cap_sid(cap_sid), .cap_stype(cap_stype), .cap_emi(cap_emi),
      .cap_oe(cap_oe), .cap_fs(cap_fs)
   );

   task automatic chk(string req, string what, int act, int exp);
      checks++;
      if (act != exp) begin
         errors++;
         $display("FAIL %s %s: actual %0d expected %0d at %0t", req, what, act, exp, $time);
      end
   endtask

   function automatic int nblk(int len, int dbs);
      int q, d;
      if (len < 8) return 0;
      q = (len - 8) / 4;
      d = (dbs == 0) ? 256 : dbs;
      return (q / d) % 256;
   endfunction

   // behavioural reference model
   int m_chan = 0, m_pd = 0, m_pb = 0, m_pe = 0, m_po = 0;
   bit m_run = 0, m_have = 0, m_armed = 0, m_busy = 0;
   bit m_valid = 0, m_keep = 0, m_first = 0, m_ifmt = 0, m_idbc = 0, m_ichg = 0;
   bit m_ffmt = 0, m_fdbc = 0, m_fchg = 0;
   int m_sid = 0, m_stype = 0, m_emi = 0, m_oe = 0, m_fs = 0;

   always @(posedge clk) begin
      if (!rst_n) begin
         m_run = 0; m_have = 0; m_armed = 0; m_busy = 0; m_chan = 0;
         m_valid = 0; m_keep = 0; m_first = 0; m_ifmt = 0; m_idbc = 0; m_ichg = 0;
         m_ffmt = 0; m_fdbc = 0; m_fchg = 0;
         m_sid = 0; m_stype = 0; m_emi = 0; m_oe = 0; m_fs = 0;
      end else begin
         bit sf, sd, sc, ok;
         int fmt, d, b;
         sf = 0; sd = 0; sc = 0;
         m_valid = 0; m_keep = 0; m_first = 0;
         if (hdr_valid && m_run && int'(iso_hdr[13:8]) == m_chan) begin
            m_valid = 1;
            m_first = m_armed;
            m_armed = 0;
            fmt = int'(cip_q1[29:24]);
            ok = (fmt == 0 && en_dv) || (fmt == 32 && en_ts) || (fmt == 33 && en_dss);
            if (!ok) sf = 1;
            else begin
               d = int'(cip_q0[7:0]);
               b = nblk(int'(iso_hdr[31:16]), int'(cip_q0[23:16]));
               if (m_have && d != ((m_pd + m_pb) % 256)) sd = 1;
               if (m_have && (int'(iso_hdr[3:2]) != m_pe || int'(iso_hdr[1]) != m_po)) sc = 1;
               m_keep = !sd;
               m_have = 1; m_pd = d; m_pb = b;
               m_pe = int'(iso_hdr[3:2]); m_po = int'(iso_hdr[1]);
               m_sid = int'(cip_q0[29:24]); m_stype = int'(cip_q1[20:16]);
               m_emi = m_pe; m_oe = m_po; m_fs = int'(cip_q1[23]);
            end
         end
         m_ifmt = sf; m_idbc = sd; m_ichg = sc;
         m_ffmt = sf | (m_ffmt & !stat_rd);
         m_fdbc = sd | (m_fdbc & !stat_rd);
         m_fchg = sc | (m_fchg & !stat_rd);
         m_busy = stop_req;
         if (chan_wr) begin
            m_chan = int'(chan_in); m_run = 1; m_have = 0; m_armed = 1;
         end else if (stop_req) m_run = 0;
      end
   end

   always @(negedge clk) begin
      if (rst_n && !done) begin
         chk("R10", "pkt_valid", pkt_valid, m_valid);
         chk("R3", "pkt_keep", pkt_keep, m_keep);
         chk("R7", "irq_first", irq_first, m_first);
         chk("R2", "irq_fmt", irq_fmt, m_ifmt);
         chk("R3", "irq_dbc", irq_dbc, m_idbc);
         chk("R5", "irq_chg", irq_chg, m_ichg);
         chk("R6", "flag_fmt", flag_fmt, m_ffmt);
         chk("R6", "flag_dbc", flag_dbc, m_fdbc);
         chk("R6", "flag_chg", flag_chg, m_fchg);
         chk("R8", "rx_active", rx_active, m_run);
         chk("R8", "stop_busy", stop_busy, m_busy);
         chk("R9", "cap_sid", cap_sid, m_sid);
         chk("R9", "cap_stype", cap_stype, m_stype);
         chk("R9", "cap_emi", cap_emi, m_emi);
         chk("R9", "cap_oe", cap_oe, m_oe);
         chk("R9", "cap_fs", cap_fs, m_fs);
      end
   end

   // drives one header for one cycle; returns at the negedge where the verdict is visible
   task automatic send(int ch, int nb, int dbs, int dbc, int fmt, int emi, int oe,
                       bit rd = 0, int lenb = -1);
      int len;
      len = (lenb >= 0) ? lenb : 8 + nb * dbs * 4;
      @(negedge clk);
      iso_hdr   = {len[15:0], 2'b01, ch[5:0], 4'hA, emi[1:0], oe[0], 1'b0};
      cip_q0    = {2'b00, 6'h2B, dbs[7:0], 8'h00, dbc[7:0]};
      cip_q1    = {2'b10, fmt[5:0], 1'b1, 2'b00, 5'h0D, 16'hFFFF};
      hdr_valid = 1'b1;
      stat_rd   = rd;
      @(negedge clk);
      hdr_valid = 1'b0;
      stat_rd   = 1'b0;
   endtask

   task automatic program_chan(int ch);
      @(negedge clk);
      chan_in = ch[5:0];
      chan_wr = 1'b1;
      @(negedge clk);
      chan_wr = 1'b0;
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         errors++;
         $display("FAIL watchdog: actual hung expected finish");
         $display("Simulation finished: %0d checks, %0d errors", checks, errors);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // reset state
      chk("R8", "reset rx_active", rx_active, 0);
      chk("R6", "reset flags", {flag_fmt, flag_dbc, flag_chg}, 0);
      send(5, 2, 6, 10, 0, 0, 0);
      chk("R1", "inactive ignore", pkt_valid, 0);

      program_chan(5);
      send(5, 2, 6, 10, 0, 0, 0);
      chk("R7", "first irq", irq_first, 1);
      chk("R4", "first no gap", irq_dbc, 0);
      send(5, 1, 6, 12, 0, 0, 0);
      chk("R3", "in-step keep", pkt_keep, 1);
      chk("R7", "first once", irq_first, 0);
      send(5, 0, 6, 13, 0, 0, 0);
      chk("R3", "empty keep", pkt_keep, 1);
      send(5, 3, 6, 13, 0, 0, 0);
      chk("R3", "after empty", irq_dbc, 0);
      send(5, 3, 6, 20, 0, 0, 0);
      chk("R3", "gap irq", irq_dbc, 1);
      chk("R3", "gap drop", pkt_keep, 0);
      send(7, 1, 6, 23, 0, 0, 0);
      chk("R1", "other channel", pkt_valid, 0);

      send(5, 1, 6, 23, 32, 0, 0);
      chk("R2", "ts disabled", irq_fmt, 1);
      en_ts = 1'b1;
      send(5, 1, 6, 23, 32, 0, 0);
      chk("R2", "ts enabled keep", pkt_keep, 1);
      send(5, 1, 6, 24, 16, 0, 0);
      chk("R2", "bad code", irq_fmt, 1);
      send(5, 1, 6, 24, 33, 2, 0);
      chk("R5", "emi change", irq_chg, 1);
      chk("R5", "emi change kept", pkt_keep, 1);
      send(5, 1, 6, 25, 33, 2, 1);
      chk("R5", "oe change", irq_chg, 1);
      chk("R9", "cap emi", cap_emi, 2);
      chk("R9", "cap oe", cap_oe, 1);
      chk("R9", "cap sid", cap_sid, 6'h2B);

      @(negedge clk); stat_rd = 1'b1;
      @(negedge clk); stat_rd = 1'b0;
      chk("R6", "read clears", {flag_fmt, flag_dbc, flag_chg}, 0);
      send(5, 1, 6, 26, 9, 2, 1, 1'b1);
      chk("R6", "set wins", flag_fmt, 1);

      send(5, 230, 6, 26, 0, 2, 1);
      send(5, 1, 6, 0, 0, 2, 1);
      chk("R3", "wrap", irq_dbc, 0);
      send(5, 0, 0, 1, 0, 2, 1, 1'b0, 8 + 1024);
      send(5, 1, 6, 2, 0, 2, 1);
      chk("R3", "dbs zero", irq_dbc, 0);

      program_chan(9);
      send(9, 1, 6, 77, 0, 0, 0);
      chk("R4", "new chan no gap", irq_dbc, 0);
      chk("R4", "new chan no chg", irq_chg, 0);
      chk("R7", "new chan first", irq_first, 1);
      send(5, 1, 6, 78, 0, 0, 0);
      chk("R1", "old chan ignored", pkt_valid, 0);

      @(negedge clk); stop_req = 1'b1;
      @(negedge clk); stop_req = 1'b0;
      chk("R8", "stop busy", stop_busy, 1);
      chk("R8", "stopped", rx_active, 0);
      @(negedge clk);
      chk("R8", "stop self clear", stop_busy, 0);
      send(9, 1, 6, 78, 0, 0, 0);
      chk("R1", "stopped ignore", pkt_valid, 0);
      repeat (3) @(negedge clk);

      done = 1'b1;
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule